// File: doc/BRIEF.md
# Masked Status Condition Evaluator

This unit turns the low control bits of a DMA descriptor command into three yes/no decisions for the channel that runs it: raise an interrupt, take a branch, or hold and wait. Each decision has its own 2-bit action mode and its own 32-bit select word. The select word carries a 4-bit mask and a 4-bit compare value. The condition for a lane is true when the device-status bits picked out by the mask equal the matching bits of the compare value.

The mode then qualifies that condition. A lane can do nothing, act when the condition holds, act when it fails, or act every time. The three lanes are identical and share one device-status input. A one-cycle evaluate strobe captures all three decisions into registers together. A valid flag rises in the following cycle. The decisions then stay put until the next strobe. Downstream logic that fetches descriptors, drives the interrupt line and picks the next command pointer consumes these registered bits.

Top module: `cond_eval_top`

## Requirements
- R1: While reset is asserted and after its release, with no strobe yet, the three decisions and the valid flag read 0.
- R2: The valid flag is 1 in exactly the cycle after a cycle with the evaluate strobe high, and 0 otherwise.
- R3: Without a strobe the three decisions keep their last captured values, whatever the other inputs do.
- R4: The interrupt lane takes its mode from command bits 5:4, the branch lane from bits 3:2 and the wait lane from bits 1:0.
- R5: Mode 2'b00 gives a decision of 0, and the select word and device status have no effect on it.
- R6: Mode 2'b11 gives a decision of 1, and the select word and device status have no effect on it.
- R7: Mode 2'b01 gives 1 exactly when the condition is true. Mode 2'b10 gives 1 exactly when it is false.
- R8: The condition is (status[3:0] & sel[19:16]) == (sel[3:0] & sel[19:16]). All other select bits are ignored.
- R9: With a zero mask the condition is true, so mode 2'b01 acts and mode 2'b10 does not.
- R10: Each lane compares against its own select word: interrupt, branch or wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Evaluate strobe, one cycle per descriptor |
| cmd_ctl_i | input | 6 | Low control bits of the descriptor command (three 2-bit modes) |
| irq_sel_i | input | 32 | Interrupt select word (mask 19:16, value 3:0) |
| br_sel_i | input | 32 | Branch select word (mask 19:16, value 3:0) |
| wait_sel_i | input | 32 | Wait select word (mask 19:16, value 3:0) |
| dev_stat_i | input | 4 | Low device-status bits of the channel |
| irq_o | output | 1 | Registered interrupt decision |
| branch_o | output | 1 | Registered branch decision |
| wait_o | output | 1 | Registered wait decision |
| valid_o | output | 1 | One-cycle flag marking freshly captured decisions |

## Verification
All four outputs are due one clock edge after the strobe. The decisions come from the inputs present at that edge. The valid flag is high only for the single cycle that follows. The bench changes inputs on the falling edge and samples on the next falling edge. A directed check therefore reads its results half a cycle after the capturing edge. In every cycle a behavioural reference model is compared with the outputs. It updates on the same rising edge and uses a bit-by-bit loop, not a masked vector compare. Hold behaviour is checked by changing every input without a strobe for several cycles and confirming that the outputs stay the same.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  // width of the compared device-status field
  localparam int STAT_W   = 4;
  // bit position of the mask inside a select word
  localparam int MASK_LSB = 16;
  // number of decision lanes (wait, branch, interrupt)
  localparam int LANES    = 3;
  localparam int MODE_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    ACT_NEVER    = 2'b00,
    ACT_IF_TRUE  = 2'b01,
    ACT_IF_FALSE = 2'b10,
    ACT_ALWAYS   = 2'b11
  } act_mode_e;

  // true when status agrees with value on every bit the mask enables
  function automatic logic masked_match(input logic [STAT_W-1:0] stat,
                                        input logic [STAT_W-1:0] mask,
                                        input logic [STAT_W-1:0] value);
    return ((stat & mask) == (value & mask));
  endfunction

  // combine the action mode with the evaluated condition
  function automatic logic qualify(input act_mode_e mode, input logic cond);
    logic res;
    case (mode)
      ACT_NEVER:    res = 1'b0;
      ACT_IF_TRUE:  res = cond;
      ACT_IF_FALSE: res = ~cond;
      default:      res = 1'b1;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cond_eval_lane.sv
module cond_eval_lane
  import cond_eval_pkg::*;
#(
  parameter int SEL_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  eval_i,
  input  logic [MODE_W-1:0]     mode_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [STAT_W-1:0]     stat_i,
  output logic                  act_o
);

  // named internal events for the checks
  act_mode_e          mode_w;
  logic [STAT_W-1:0]  mask_w;
  logic [STAT_W-1:0]  value_w;
  logic               cond_w;
  logic               decide_w;

  assign mode_w   = act_mode_e'(mode_i);
  assign mask_w   = sel_i[MASK_LSB +: STAT_W];
  assign value_w  = sel_i[0 +: STAT_W];
  assign cond_w   = masked_match(stat_i, mask_w, value_w);
  assign decide_w = qualify(mode_w, cond_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_o <= 1'b0;
    else if (eval_i) act_o <= decide_w;
  end

  // R5
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && mode_i == 2'b00) |=> !act_o);

  // R6
  always_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && mode_i == 2'b11) |=> act_o);

  // R7
  if_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && mode_i == 2'b01) |=> (act_o == $past(cond_w)));

  // R7
  if_false_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && mode_i == 2'b10) |=> (act_o != $past(cond_w)));

  // R9
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && mode_i == 2'b01 && sel_i[MASK_LSB +: STAT_W] == '0) |=> act_o);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> $stable(act_o));

endmodule

// File: rtl/cond_eval_top.sv
module cond_eval_top
  import cond_eval_pkg::*;
#(
  parameter int SEL_W = 32,
  localparam int CTL_W = LANES * MODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eval_i,
  input  logic [CTL_W-1:0]   cmd_ctl_i,
  input  logic [SEL_W-1:0]   irq_sel_i,
  input  logic [SEL_W-1:0]   br_sel_i,
  input  logic [SEL_W-1:0]   wait_sel_i,
  input  logic [STAT_W-1:0]  dev_stat_i,
  output logic               irq_o,
  output logic               branch_o,
  output logic               wait_o,
  output logic               valid_o
);

  // lane 0 = wait, lane 1 = branch, lane 2 = interrupt;
  // lane g reads its mode from command bits [2g+1:2g]
  logic [LANES-1:0][SEL_W-1:0] sel_w;
  logic [LANES-1:0]            act_w;

  assign sel_w[0] = wait_sel_i;
  assign sel_w[1] = br_sel_i;
  assign sel_w[2] = irq_sel_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cond_eval_lane #(.SEL_W(SEL_W)) lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .eval_i (eval_i),
      .mode_i (cmd_ctl_i[g*MODE_W +: MODE_W]),
      .sel_i  (sel_w[g]),
      .stat_i (dev_stat_i),
      .act_o  (act_w[g])
    );
  end

  assign wait_o   = act_w[0];
  assign branch_o = act_w[1];
  assign irq_o    = act_w[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= eval_i;
  end

  // R2
  valid_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |=> valid_o);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> !valid_o);

  // R4
  irq_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cmd_ctl_i[5:4] == 2'b11) |=> irq_o);

  // R4
  wait_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cmd_ctl_i[1:0] == 2'b00) |=> !wait_o);

endmodule

// File: tb/cond_eval_top_tb_top.sv
module cond_eval_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_i = 1'b0;
  logic [5:0]  cmd_ctl_i = '0;
  logic [31:0] irq_sel_i = '0;
  logic [31:0] br_sel_i = '0;
  logic [31:0] wait_sel_i = '0;
  logic [3:0]  dev_stat_i = '0;
  logic        irq_o, branch_o, wait_o, valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit m_irq, m_br, m_wait, m_valid;

  always #5 clk = ~clk;

  cond_eval_top dut_i (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .cmd_ctl_i(cmd_ctl_i),
    .irq_sel_i(irq_sel_i), .br_sel_i(br_sel_i), .wait_sel_i(wait_sel_i),
    .dev_stat_i(dev_stat_i), .irq_o(irq_o), .branch_o(branch_o),
    .wait_o(wait_o), .valid_o(valid_o)
  );

  // condition computed bit by bit from the requirement text (R8)
  function automatic bit ref_cond(input logic [31:0] sel, input logic [3:0] st);
    bit ok = 1;
    for (int i = 0; i < 4; i++)
      if (sel[16+i] && (st[i] != sel[i])) ok = 0;
    return ok;
  endfunction

  function automatic bit ref_act(input int mode, input logic [31:0] sel,
                                 input logic [3:0] st);
    if (mode == 0) return 0;
    if (mode == 3) return 1;
    if (mode == 1) return ref_cond(sel, st);
    return !ref_cond(sel, st);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irq <= 0; m_br <= 0; m_wait <= 0; m_valid <= 0;
    end else begin
      m_valid <= eval_i;
      if (eval_i) begin
        m_irq  <= ref_act(int'(cmd_ctl_i[5:4]), irq_sel_i, dev_stat_i);
        m_br   <= ref_act(int'(cmd_ctl_i[3:2]), br_sel_i, dev_stat_i);
        m_wait <= ref_act(int'(cmd_ctl_i[1:0]), wait_sel_i, dev_stat_i);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle model compare (R2, R3 and all decision rules)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model valid", {31'd0, valid_o}, {31'd0, m_valid});
      chk("R3 model decisions", {29'd0, irq_o, branch_o, wait_o},
          {29'd0, m_irq, m_br, m_wait});
    end
  end

  // drive one strobe at the falling edge, sample at the next falling edge
  task automatic strobe(input logic [5:0] ctl, input logic [31:0] isel,
                        input logic [31:0] bsel, input logic [31:0] wsel,
                        input logic [3:0] st);
    @(negedge clk);
    cmd_ctl_i = ctl; irq_sel_i = isel; br_sel_i = bsel; wait_sel_i = wsel;
    dev_stat_i = st; eval_i = 1'b1;
    @(negedge clk);
    eval_i = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] outs();
    return {29'd0, irq_o, branch_o, wait_o};
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    #23;
    chk("R1 reset outs", {28'd0, irq_o, branch_o, wait_o, valid_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 after release", {28'd0, irq_o, branch_o, wait_o, valid_o}, 32'd0);

    // R4 + R6 + R5: interrupt lane always, others never
    strobe(6'b110000, 32'h000F_0000, 32'h0, 32'h0, 4'h0);
    chk("R4 irq field", outs(), 32'b100);
    chk("R2 valid after strobe", {31'd0, valid_o}, 32'd1);
    @(negedge clk); #1;
    chk("R2 valid drops", {31'd0, valid_o}, 32'd0);

    strobe(6'b001100, 32'h0, 32'h0, 32'h0, 4'h0);
    chk("R4 branch field", outs(), 32'b010);
    strobe(6'b000011, 32'h0, 32'h0, 32'h0, 4'h0);
    chk("R4 wait field", outs(), 32'b001);

    // R5 never ignores matching selects
    strobe(6'b000000, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 4'h5);
    chk("R5 never", outs(), 32'b000);
    // R6 always ignores failing selects
    strobe(6'b111111, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 4'hA);
    chk("R6 always", outs(), 32'b111);

    // R7 if-true / if-false
    strobe(6'b010101, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 4'h5);
    chk("R7 if-true met", outs(), 32'b111);
    strobe(6'b010101, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 4'h4);
    chk("R7 if-true unmet", outs(), 32'b000);
    strobe(6'b101010, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 4'h4);
    chk("R7 if-false unmet", outs(), 32'b111);
    strobe(6'b101010, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 4'h5);
    chk("R7 if-false met", outs(), 32'b000);

    // R8 junk in unused select bits; mask 3 value 5 -> compares low bits to 01
    strobe(6'b010101, 32'hFFF3_FFF5, 32'hFFF3_FFF5, 32'hFFF3_FFF5, 4'hD);
    chk("R8 junk ignored", outs(), 32'b111);
    strobe(6'b010101, 32'hFFF3_FFF5, 32'hFFF3_FFF5, 32'hFFF3_FFF5, 4'hE);
    chk("R8 masked mismatch", outs(), 32'b000);

    // R9 zero mask
    strobe(6'b011001, 32'h0000_000F, 32'h0000_000F, 32'h0000_000F, 4'h0);
    chk("R9 zero mask", outs(), 32'b101);

    // R10 separate select words per lane
    strobe(6'b010101, 32'h000F_0003, 32'h000F_0007, 32'h000C_000C, 4'hF);
    chk("R10 per-lane select", outs(), 32'b001);

    // R3 hold while inputs change without a strobe
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cmd_ctl_i = 6'(k * 11); dev_stat_i = 4'(k * 3);
      irq_sel_i = 32'h000F_0000 | 32'(k); br_sel_i = ~br_sel_i;
    end
    @(negedge clk); #1;
    chk("R3 hold", outs(), 32'b001);

    // mixed sequence checked by the model every cycle
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      eval_i = (k % 3) != 1;
      cmd_ctl_i = 6'((k * 37 + 5) % 64);
      dev_stat_i = 4'((k * 7) % 16);
      irq_sel_i  = {12'((k * 13)), 4'((k * 5) % 16), 12'(k), 4'((k * 9) % 16)};
      br_sel_i   = {12'd0, 4'((k * 3) % 16), 12'hABC, 4'((k * 11) % 16)};
      wait_sel_i = {12'hFFF, 4'(k % 16), 12'd0, 4'((k + 6) % 16)};
    end
    @(negedge clk); eval_i = 1'b0;
    @(negedge clk); #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule